// File: doc/BRIEF.md
# Bus Transaction Attribute Override Region

This block sits on an outgoing bus path and rewrites the side-band attributes that travel with each transaction: the secure flag, two privilege bits, an 8-bit privilege identifier, a 12-bit virtual identifier and a 2-bit address type. The rewrite follows one of several programmable regions. The transaction decoder outside the block picks the region, and the block produces the rewritten attributes combinationally, in the same cycle as the incoming ones.

Each region has two 32-bit control words. They are written and read back over a small register port made of address, write enable, write data and read data. A region does nothing until its enable field holds a magic key. Software can freeze a region with a sticky lock bit that only reset can clear. Set and clear controls for the secure flag and the privilege bits follow fixed precedence rules: clear or force-non-secure always wins.

Top module: `attr_ovr`

## Requirements
- R1: After reset, every control word reads as zero, every region is disabled and unlocked, and every outgoing attribute equals the incoming one.
- R2: A region is active only when bits [3:0] of its word 0 hold 4'hA. With any other key value, every outgoing attribute equals the incoming one, whatever the other fields hold.
- R3: Bit 31 of word 0 is a lock that can only be set by writing 1. Writing 0 does not clear it. Once it is set, writes to both words of that region are ignored and leave the readback and the outgoing attributes unchanged until reset.
- R4: In an active region, the outgoing secure flag is 1 when bits [7:4] of word 0 hold 4'hA and otherwise follows the incoming flag. Bit 8 of word 0 forces the flag to 0 and takes precedence over the secure key.
- R5: In an active region, bits [11:10] of word 0 set the matching outgoing privilege bits and bits [13:12] clear them. Where both are set for a bit, clear wins.
- R6: In an active region, the outgoing privilege ID is bits [23:16] of word 0 unless the pass bit, bit 9 of word 0, is 1. When the pass bit is 1, the incoming ID is passed through.
- R7: In an active region, the outgoing virtual ID is bits [11:0] of word 1 unless the pass bit, bit 15 of word 1, is 1. When the pass bit is 1, the incoming ID is passed through.
- R8: In an active region, the outgoing address type is bits [13:12] of word 1, encoded as 0 = physical without memory attributes, 1 = intermediate, 2 = virtual, 3 = physical with memory attributes.
- R9: The register address has its bit 0 selecting the word (0 = word 0, 1 = word 1) and its upper bits selecting the region. Readback is combinational, and the unused bits read as zero: word 0 keeps the mask 32'h80FF3FFF and word 1 keeps 32'h0000BFFF.
- R10: The region-select input picks the region applied to the attributes, and the outgoing attributes follow the inputs and the selection in the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr | input | ADDR_W | Register address: region index above, word select in bit 0 |
| cfg_we | input | 1 | Register write enable |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr |
| region_sel | input | SEL_W | Region applied to the current transaction |
| in_secure | input | 1 | Incoming secure flag |
| in_priv | input | 2 | Incoming privilege bits |
| in_privid | input | PID_W | Incoming privilege ID |
| in_virtid | input | VID_W | Incoming virtual ID |
| in_atype | input | 2 | Incoming address type |
| out_secure | output | 1 | Rewritten secure flag |
| out_priv | output | 2 | Rewritten privilege bits |
| out_privid | output | PID_W | Rewritten privilege ID |
| out_virtid | output | VID_W | Rewritten virtual ID |
| out_atype | output | 2 | Rewritten address type |

## Verification
The hardest state to reach from the ports is a locked region that is then hit with writes to both of its words. Those writes must leave both the readback and the rewritten attributes untouched. The stimulus first programs a region and sets its lock in a single write. It then tries new values in word 0, with the lock bit written as 0, and in word 1, and checks both readback and attributes after each attempt. An all-ones write to another region sets its lock as a side effect, so the reserved-bit masking and the locking path are also exercised together.

// File: rtl/attr_ovr_pkg.sv
package attr_ovr_pkg;

    localparam int          PID_W   = 8;
    localparam int          VID_W   = 12;
    localparam int          WORD_W  = 32;
    localparam logic [3:0]  KEY_ON  = 4'hA;

    typedef struct packed {
        logic              lock;
        logic [PID_W-1:0]  privid;
        logic [1:0]        priv_clr;
        logic [1:0]        priv_set;
        logic              pid_pass;
        logic              nonsec;
        logic [3:0]        sec_key;
        logic [3:0]        en_key;
    } ctl0_t;

    typedef struct packed {
        logic              vid_pass;
        logic [1:0]        atype;
        logic [VID_W-1:0]  virtid;
    } ctl1_t;

    typedef struct packed {
        ctl0_t c0;
        ctl1_t c1;
    } region_state_t;

    typedef struct packed {
        logic              secure;
        logic [1:0]        priv;
        logic [PID_W-1:0]  privid;
        logic [VID_W-1:0]  virtid;
        logic [1:0]        atype;
    } attr_t;

    function automatic logic [WORD_W-1:0] pack0(ctl0_t c);
        logic [WORD_W-1:0] w;
        w          = '0;
        w[3:0]     = c.en_key;
        w[7:4]     = c.sec_key;
        w[8]       = c.nonsec;
        w[9]       = c.pid_pass;
        w[11:10]   = c.priv_set;
        w[13:12]   = c.priv_clr;
        w[23:16]   = c.privid;
        w[31]      = c.lock;
        return w;
    endfunction

    function automatic ctl0_t unpack0(logic [WORD_W-1:0] w);
        ctl0_t c;
        c.en_key   = w[3:0];
        c.sec_key  = w[7:4];
        c.nonsec   = w[8];
        c.pid_pass = w[9];
        c.priv_set = w[11:10];
        c.priv_clr = w[13:12];
        c.privid   = w[23:16];
        c.lock     = w[31];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] pack1(ctl1_t c);
        logic [WORD_W-1:0] w;
        w          = '0;
        w[11:0]    = c.virtid;
        w[13:12]   = c.atype;
        w[15]      = c.vid_pass;
        return w;
    endfunction

    function automatic ctl1_t unpack1(logic [WORD_W-1:0] w);
        ctl1_t c;
        c.virtid   = w[11:0];
        c.atype    = w[13:12];
        c.vid_pass = w[15];
        return c;
    endfunction

endpackage

// File: rtl/attr_region_regs.sv
module attr_region_regs
    import attr_ovr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr0,
    input  logic              wr1,
    input  logic [WORD_W-1:0] wdata,
    output ctl0_t             c0,
    output ctl1_t             c1
);

    region_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Once locked, both words are frozen until reset.
        if (!st_q.c0.lock) begin
            if (wr0) st_d.c0 = unpack0(wdata);
            if (wr1) st_d.c1 = unpack1(wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign c0 = st_q.c0;
    assign c1 = st_q.c1;

endmodule

// File: rtl/attr_rewrite.sv
module attr_rewrite
    import attr_ovr_pkg::*;
(
    input  ctl0_t c0,
    input  ctl1_t c1,
    input  attr_t a_in,
    output attr_t a_out
);

    logic active;

    always_comb begin
        active = (c0.en_key == KEY_ON);
        a_out  = a_in;
        if (active) begin
            // Force-non-secure wins over the secure key.
            if (c0.nonsec)                 a_out.secure = 1'b0;
            else if (c0.sec_key == KEY_ON) a_out.secure = 1'b1;
            // Clear wins over set, bit by bit.
            a_out.priv  = (a_in.priv | c0.priv_set) & ~c0.priv_clr;
            if (!c0.pid_pass) a_out.privid = c0.privid;
            if (!c1.vid_pass) a_out.virtid = c1.virtid;
            a_out.atype = c1.atype;
        end
    end

endmodule

// File: rtl/attr_ovr.sv
module attr_ovr
    import attr_ovr_pkg::*;
#(
    parameter int NUM_REGIONS = 4,
    localparam int SEL_W  = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1,
    localparam int ADDR_W = SEL_W + 1
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              cfg_we,
    input  logic [WORD_W-1:0] cfg_wdata,
    output logic [WORD_W-1:0] cfg_rdata,
    input  logic [SEL_W-1:0]  region_sel,
    input  logic              in_secure,
    input  logic [1:0]        in_priv,
    input  logic [PID_W-1:0]  in_privid,
    input  logic [VID_W-1:0]  in_virtid,
    input  logic [1:0]        in_atype,
    output logic              out_secure,
    output logic [1:0]        out_priv,
    output logic [PID_W-1:0]  out_privid,
    output logic [VID_W-1:0]  out_virtid,
    output logic [1:0]        out_atype
);

    localparam int SEL_N = 1 << SEL_W;

    ctl0_t [NUM_REGIONS-1:0] c0_q;
    ctl1_t [NUM_REGIONS-1:0] c1_q;
    ctl0_t [SEL_N-1:0]       c0_pad;
    ctl1_t [SEL_N-1:0]       c1_pad;

    logic [SEL_W-1:0] cfg_idx;
    assign cfg_idx = cfg_addr[ADDR_W-1:1];

    for (genvar g = 0; g < SEL_N; g++) begin : g_reg
        if (g < NUM_REGIONS) begin : g_live
            logic wr0, wr1;
            assign wr0 = cfg_we && !cfg_addr[0] && (cfg_idx == SEL_W'(g));
            assign wr1 = cfg_we &&  cfg_addr[0] && (cfg_idx == SEL_W'(g));
            attr_region_regs u_regs (
                .clk   (clk),
                .rst_n (rst_n),
                .wr0   (wr0),
                .wr1   (wr1),
                .wdata (cfg_wdata),
                .c0    (c0_q[g]),
                .c1    (c1_q[g])
            );
            assign c0_pad[g] = c0_q[g];
            assign c1_pad[g] = c1_q[g];
        end else begin : g_none
            assign c0_pad[g] = '0;
            assign c1_pad[g] = '0;
        end
    end

    assign cfg_rdata = cfg_addr[0] ? pack1(c1_pad[cfg_idx]) : pack0(c0_pad[cfg_idx]);

    attr_t a_in, a_out;
    assign a_in = '{secure: in_secure, priv: in_priv, privid: in_privid,
                    virtid: in_virtid, atype: in_atype};

    attr_rewrite u_rw (
        .c0    (c0_pad[region_sel]),
        .c1    (c1_pad[region_sel]),
        .a_in  (a_in),
        .a_out (a_out)
    );

    assign out_secure = a_out.secure;
    assign out_priv   = a_out.priv;
    assign out_privid = a_out.privid;
    assign out_virtid = a_out.virtid;
    assign out_atype  = a_out.atype;

endmodule

// File: rtl/attr_ovr_chk.sv
module attr_ovr_chk
    import attr_ovr_pkg::*;
#(
    parameter int NUM_REGIONS = 4,
    localparam int SEL_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
)(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [SEL_W-1:0]        region_sel,
    input  logic                    in_secure,
    input  logic [1:0]              in_priv,
    input  logic [PID_W-1:0]        in_privid,
    input  logic [VID_W-1:0]        in_virtid,
    input  logic [1:0]              in_atype,
    input  logic                    out_secure,
    input  logic [1:0]              out_priv,
    input  logic [PID_W-1:0]        out_privid,
    input  logic [VID_W-1:0]        out_virtid,
    input  logic [1:0]              out_atype,
    input  ctl0_t [NUM_REGIONS-1:0] c0_all,
    input  ctl1_t [NUM_REGIONS-1:0] c1_all
);

    ctl0_t s0;
    ctl1_t s1;
    logic  on;
    assign s0 = c0_all[region_sel];
    assign s1 = c1_all[region_sel];
    assign on = (s0.en_key == KEY_ON);

    a_r2_disabled_pass: assert property (@(posedge clk) disable iff (!rst_n)
        !on |-> (out_secure == in_secure && out_priv == in_priv &&
                 out_privid == in_privid && out_virtid == in_virtid &&
                 out_atype == in_atype));

    a_r4_nonsec_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (on && s0.nonsec) |-> !out_secure);

    a_r5_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        on |-> ((out_priv & s0.priv_clr) == 2'b00));

    a_r6_privid_replace: assert property (@(posedge clk) disable iff (!rst_n)
        (on && !s0.pid_pass) |-> (out_privid == s0.privid));

    a_r7_virtid_replace: assert property (@(posedge clk) disable iff (!rst_n)
        (on && !s1.vid_pass) |-> (out_virtid == s1.virtid));

    a_r8_atype_drive: assert property (@(posedge clk) disable iff (!rst_n)
        on |-> (out_atype == s1.atype));

    for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_lock
        a_r3_lock_frozen: assert property (@(posedge clk) disable iff (!rst_n)
            c0_all[i].lock |=> (c0_all[i].lock && $stable(c0_all[i]) && $stable(c1_all[i])));
    end

endmodule

bind attr_ovr attr_ovr_chk #(.NUM_REGIONS(NUM_REGIONS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .region_sel (region_sel),
    .in_secure  (in_secure),
    .in_priv    (in_priv),
    .in_privid  (in_privid),
    .in_virtid  (in_virtid),
    .in_atype   (in_atype),
    .out_secure (out_secure),
    .out_priv   (out_priv),
    .out_privid (out_privid),
    .out_virtid (out_virtid),
    .out_atype  (out_atype),
    .c0_all     (c0_q),
    .c1_all     (c1_q)
);

// File: tb/attr_ovr_tb.sv
`timescale 1ns/1ps
module attr_ovr_tb;

    localparam int NR  = 4;
    localparam int SW  = 2;
    localparam int AW  = 3;
    localparam int WD_CYCLES = 100000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic          cfg_we = 1'b0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   cfg_rdata;
    logic [SW-1:0] region_sel = '0;
    logic          in_secure = 1'b0;
    logic [1:0]    in_priv = '0;
    logic [7:0]    in_privid = '0;
    logic [11:0]   in_virtid = '0;
    logic [1:0]    in_atype = '0;
    logic          out_secure;
    logic [1:0]    out_priv;
    logic [7:0]    out_privid;
    logic [11:0]   out_virtid;
    logic [1:0]    out_atype;

    always #10 clk = ~clk;

    attr_ovr #(.NUM_REGIONS(NR)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .region_sel(region_sel),
        .in_secure(in_secure), .in_priv(in_priv), .in_privid(in_privid),
        .in_virtid(in_virtid), .in_atype(in_atype), .out_secure(out_secure),
        .out_priv(out_priv), .out_privid(out_privid), .out_virtid(out_virtid),
        .out_atype(out_atype)
    );

    typedef struct {
        string       tag;
        logic        sec;
        logic [1:0]  priv;
        logic [7:0]  pid;
        logic [11:0] vid;
        logic [1:0]  at;
        logic [31:0] rd;
    } exp_t;

    exp_t   sb[$];
    event   chk_ev;
    int     n_chk = 0;
    int     n_fail = 0;
    bit     done = 1'b0;
    logic [31:0] sh0 [NR];
    logic [31:0] sh1 [NR];

    function automatic logic [31:0] mk0(logic [3:0] en, logic [3:0] sk, logic ns,
                                        logic pp, logic [1:0] ps, logic [1:0] pc,
                                        logic [7:0] pid, logic lk);
        return (32'(lk) << 31) | (32'(pid) << 16) | (32'(pc) << 12) | (32'(ps) << 10)
             | (32'(pp) << 9) | (32'(ns) << 8) | (32'(sk) << 4) | 32'(en);
    endfunction

    function automatic logic [31:0] mk1(logic vp, logic [1:0] at, logic [11:0] vid);
        return (32'(vp) << 15) | (32'(at) << 12) | 32'(vid);
    endfunction

    task automatic wr(int reg_idx, bit word, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = AW'((reg_idx << 1) | int'(word)); cfg_wdata = d;
        // R3: model of the sticky lock, R9: model of the kept bits
        if (!sh0[reg_idx][31]) begin
            if (word) sh1[reg_idx] = d & 32'h0000BFFF;
            else      sh0[reg_idx] = d & 32'h80FF3FFF;
        end
        @(posedge clk); #1 cfg_we = 1'b0;
    endtask

    task automatic apply(string tag, int sel, logic s, logic [1:0] p, logic [7:0] pid,
                         logic [11:0] vid, logic [1:0] at, int rd_addr);
        exp_t e;
        logic [31:0] w0, w1;
        @(negedge clk);
        region_sel = SW'(sel); in_secure = s; in_priv = p; in_privid = pid;
        in_virtid = vid; in_atype = at; cfg_addr = AW'(rd_addr);
        w0 = sh0[sel]; w1 = sh1[sel];
        e.tag = tag; e.sec = s; e.priv = p; e.pid = pid; e.vid = vid; e.at = at;
        if (w0[3:0] == 4'hA) begin
            if (w0[8])               e.sec = 1'b0;
            else if (w0[7:4] == 4'hA) e.sec = 1'b1;
            e.priv = (p | w0[11:10]) & ~w0[13:12];
            if (!w0[9])  e.pid = w0[23:16];
            if (!w1[15]) e.vid = w1[11:0];
            e.at = w1[13:12];
        end
        e.rd = rd_addr[0] ? sh1[rd_addr >> 1] : sh0[rd_addr >> 1];
        sb.push_back(e);
        #5 ->chk_ev;
    endtask

    always begin
        @(chk_ev);
        while (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_chk++;
            if (out_secure !== e.sec || out_priv !== e.priv || out_privid !== e.pid ||
                out_virtid !== e.vid || out_atype !== e.at || cfg_rdata !== e.rd) begin
                n_fail++;
                $display("FAIL %s: got sec=%0b priv=%b pid=%h vid=%h at=%0d rd=%h, exp sec=%0b priv=%b pid=%h vid=%h at=%0d rd=%h",
                    e.tag, out_secure, out_priv, out_privid, out_virtid, out_atype, cfg_rdata,
                    e.sec, e.priv, e.pid, e.vid, e.at, e.rd);
            end
        end
    end

    initial begin
        #(WD_CYCLES * 20);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got running, exp finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NR; i++) begin sh0[i] = '0; sh1[i] = '0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state, every region reads zero and passes through
        for (int i = 0; i < NR; i++) begin
            apply("R1 reset word0", i, 1'b1, 2'b10, 8'h5C, 12'hABC, 2'd3, i << 1);
            apply("R1 reset word1", i, 1'b0, 2'b01, 8'h13, 12'h246, 2'd1, (i << 1) | 1);
        end

        // R2: wrong keys leave attributes untouched
        wr(0, 1'b1, mk1(1'b0, 2'd2, 12'h5A5));
        wr(0, 1'b0, mk0(4'h5, 4'hA, 1'b0, 1'b0, 2'b11, 2'b00, 8'h3C, 1'b0));
        apply("R2 key 5 passes", 0, 1'b0, 2'b00, 8'h11, 12'h111, 2'd1, 0);
        wr(0, 1'b0, mk0(4'hB, 4'hA, 1'b0, 1'b0, 2'b11, 2'b00, 8'h3C, 1'b0));
        apply("R2 key B passes", 0, 1'b0, 2'b00, 8'h22, 12'h222, 2'd0, 0);

        // R4 R5 R6 R7 R8: active region overrides
        wr(0, 1'b0, mk0(4'hA, 4'hA, 1'b0, 1'b0, 2'b01, 2'b00, 8'h3C, 1'b0));
        apply("R4 secure key set", 0, 1'b0, 2'b00, 8'h77, 12'h777, 2'd0, 0);
        apply("R5 set bit0", 0, 1'b1, 2'b10, 8'h00, 12'h000, 2'd3, 1);
        apply("R6 R7 R8 replaced", 0, 1'b0, 2'b00, 8'hFF, 12'hFFF, 2'd1, 1);

        // R4: force-non-secure beats key; non-key follows input
        wr(1, 1'b0, mk0(4'hA, 4'hA, 1'b1, 1'b0, 2'b00, 2'b00, 8'h01, 1'b0));
        apply("R4 nonsec wins", 1, 1'b1, 2'b11, 8'h40, 12'h400, 2'd2, 2);
        wr(1, 1'b0, mk0(4'hA, 4'h3, 1'b0, 1'b0, 2'b00, 2'b00, 8'h01, 1'b0));
        apply("R4 key off in=1", 1, 1'b1, 2'b00, 8'h40, 12'h400, 2'd2, 2);
        apply("R4 key off in=0", 1, 1'b0, 2'b00, 8'h40, 12'h400, 2'd2, 2);

        // R5: clear beats set per bit; R6 R7 pass bits
        wr(1, 1'b0, mk0(4'hA, 4'h0, 1'b0, 1'b1, 2'b11, 2'b10, 8'h99, 1'b0));
        wr(1, 1'b1, mk1(1'b1, 2'd3, 12'h321));
        apply("R5 clear wins in00", 1, 1'b0, 2'b00, 8'h42, 12'h0F0, 2'd0, 3);
        apply("R5 clear wins in11", 1, 1'b0, 2'b11, 8'h42, 12'h0F0, 2'd0, 3);
        apply("R6 R7 pass through", 1, 1'b1, 2'b01, 8'hE7, 12'hD0D, 2'd1, 2);

        // R10: same inputs, different region selects
        apply("R10 sel0", 0, 1'b0, 2'b00, 8'h55, 12'h555, 2'd1, 0);
        apply("R10 sel1", 1, 1'b0, 2'b00, 8'h55, 12'h555, 2'd1, 2);

        // R9: reserved bits read zero (all-ones also sets the lock of region 2)
        wr(2, 1'b1, 32'hFFFF_FFFF);
        apply("R9 word1 mask", 2, 1'b0, 2'b00, 8'h00, 12'h000, 2'd0, 5);
        wr(2, 1'b0, 32'hFFFF_FFFF);
        apply("R9 word0 mask", 2, 1'b0, 2'b00, 8'h00, 12'h000, 2'd0, 4);
        wr(2, 1'b1, 32'h0000_0000);
        apply("R3 locked word1 kept", 2, 1'b1, 2'b11, 8'h12, 12'h345, 2'd0, 5);

        // R3: lock set together with fields, then writes ignored
        wr(3, 1'b1, mk1(1'b0, 2'd1, 12'hCAF));
        wr(3, 1'b0, mk0(4'hA, 4'hA, 1'b0, 1'b0, 2'b10, 2'b01, 8'hB4, 1'b1));
        apply("R3 locked active", 3, 1'b0, 2'b01, 8'h00, 12'h000, 2'd3, 6);
        wr(3, 1'b0, mk0(4'h0, 4'h0, 1'b0, 1'b1, 2'b00, 2'b00, 8'h00, 1'b0));
        apply("R3 word0 write ignored", 3, 1'b0, 2'b01, 8'h00, 12'h000, 2'd3, 6);
        wr(3, 1'b1, mk1(1'b1, 2'd0, 12'h000));
        apply("R3 word1 write ignored", 3, 1'b1, 2'b00, 8'h66, 12'h666, 2'd2, 7);

        // R8: address-type encodings through an unlocked region
        for (int t = 0; t < 4; t++) begin
            wr(0, 1'b1, mk1(1'b0, 2'(t), 12'h5A5));
            apply("R8 atype value", 0, 1'b0, 2'b00, 8'h00, 12'h000, 2'(3 - t), 1);
        end

        // R3: reset is the only way out of the lock
        @(negedge clk); rst_n = 1'b0;
        for (int i = 0; i < NR; i++) begin sh0[i] = '0; sh1[i] = '0; end
        @(negedge clk); rst_n = 1'b1;
        apply("R3 R1 reset clears lock", 3, 1'b0, 2'b01, 8'h21, 12'h021, 2'd2, 6);

        @(negedge clk);
        #6;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule